// File: doc/BRIEF.md
# Predicate and Conditional Execution Unit

This unit keeps the predicate bit of a small in-order core together with two short-lived control windows. The first, the condition window, marks some of the next few instructions for skipping. It does so by comparing one bit of a stored pattern per instruction with the predicate. The second, the modifier window, stays in force for a counted number of instructions. During that span it does one of two jobs. It can tell the ALU to chain its carry. It can also make compares merge their result into the predicate with AND or OR instead of overwriting it.

Each instruction presents its command on the input side in the cycle it retires, marked by `retire`. The command can be a compare, a condition-window load, a modifier-window load or a direct predicate write. The unit reports, from registered state only, whether the instruction now retiring must be skipped. A skipped instruction still uses up one slot of each active window, but its own command is discarded. The two windows are held in separate registers and can both be active at once.

Top module: `pcx_unit`

## Requirements
- R1: After reset `pred_o`, `skip_o` and `carry_en_o` are all 0.
- R2: A retired, unskipped compare with `cmp_op` 0..6 evaluates B and C as: 0 equal, 1 not equal, 2 signed less-than, 3 unsigned less-than, 4 signed greater-or-equal, 5 unsigned greater-or-equal, 6 any common set bit ((B & C) != 0). Outside an AND/OR window the result replaces the predicate.
- R3: Compare code 7 takes its result from `pin_in[pin_sel]`.
- R4: A compare with `cmp_xform` = 1 arms a condition window of length one with pattern bit 1. The next retired instruction is skipped exactly when the updated predicate is 0.
- R5: A condition-window load takes `cex_mask` and `cex_len`. A length above 8 is clamped to 8. The k-th retired instruction after it (k = 0 first) has `skip_o` = 1 exactly when `cex_mask[k]` differs from the predicate at that time. Once the length is used up, nothing is skipped.
- R6: A modifier-window load sets the mode from `cnt_mode` (0 carry, 1 AND, 2 OR, 3 no effect) and the count from `cnt_len`. With mode 0, `carry_en_o` is 1 for the next `cnt_len` retired instructions and 0 afterwards.
- R7: While an AND (1) or OR (2) window has count left, a compare folds its result into the predicate with AND or OR respectively.
- R8: A skipped instruction leaves the predicate and both windows' contents unchanged, and its command has no effect. Every retired instruction, skipped or not, uses up one slot of each active window.
- R9: A retired, unskipped `putp_valid` sets the predicate to `putp_bit`. This write ignores any AND/OR window.
- R10: The instruction that loads a window is not counted in it. Cycles with `retire` = 0 change no state, whatever the other inputs are.
- R11: A condition window and a modifier window run at the same time without affecting each other's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| retire | input | 1 | The current instruction retires this cycle |
| cmp_valid | input | 1 | Current instruction is a compare |
| cmp_op | input | 3 | Compare code |
| cmp_xform | input | 1 | Compare also arms a one-instruction condition window |
| opnd_b | input | W | Compare operand B |
| opnd_c | input | W | Compare operand C |
| pin_in | input | PINS | Input pins for compare code 7 |
| pin_sel | input | SEL_W | Pin index for compare code 7 |
| cex_valid | input | 1 | Current instruction loads the condition window |
| cex_mask | input | MASK_W | Skip pattern, bit 0 for the first covered instruction |
| cex_len | input | LEN_W | Number of covered instructions |
| cnt_valid | input | 1 | Current instruction loads the modifier window |
| cnt_mode | input | 2 | Window mode: 0 carry, 1 AND, 2 OR |
| cnt_len | input | LEN_W | Number of covered instructions |
| putp_valid | input | 1 | Current instruction writes the predicate directly |
| putp_bit | input | 1 | Low bit of the direct-write operand |
| pred_o | output | 1 | Predicate |
| skip_o | output | 1 | The retiring instruction must be skipped |
| carry_en_o | output | 1 | ALU carry chaining enabled |

## Verification
The assertions assume that on a retiring cycle at most one of the four command valids is high, because an instruction carries a single command. Commands that arrive with `retire` low are assumed to be don't-cares. The stimulus drives exactly one command kind, or none, on every retiring cycle. On idle cycles it deliberately drives random, possibly overlapping valids, to show that they are ignored. Because the skip and carry outputs depend only on registered state, the properties can relate them to the previous retiring cycle without looking at the inputs of the current one.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

  typedef enum logic [1:0] {
    MODE_CARRY = 2'd0,
    MODE_ANDP  = 2'd1,
    MODE_ORP   = 2'd2,
    MODE_NONE  = 2'd3
  } win_mode_e;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LT  = 3'd2,
    CMP_LTU = 3'd3,
    CMP_GE  = 3'd4,
    CMP_GEU = 3'd5,
    CMP_ANY = 3'd6,
    CMP_PIN = 3'd7
  } cmp_op_e;

endpackage

// File: rtl/pcx_compare.sv
module pcx_compare
  import pcx_pkg::*;
#(
  parameter int W    = 16,
  parameter int PINS = 4,
  localparam int SEL_W = $clog2(PINS)
) (
  input  logic [2:0]       op,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     c,
  input  logic [PINS-1:0]  pins,
  input  logic [SEL_W-1:0] sel,
  output logic             result
);

  logic eq, lt_s, lt_u, any_bit;

  assign eq      = (b == c);
  assign lt_s    = ($signed(b) < $signed(c));
  assign lt_u    = (b < c);
  assign any_bit = |(b & c);

  always_comb begin
    unique case (cmp_op_e'(op))
      CMP_EQ:  result = eq;
      CMP_NE:  result = ~eq;
      CMP_LT:  result = lt_s;
      CMP_LTU: result = lt_u;
      CMP_GE:  result = ~lt_s;
      CMP_GEU: result = ~lt_u;
      CMP_ANY: result = any_bit;
      default: result = pins[sel];
    endcase
  end

endmodule

// File: rtl/pcx_cond_track.sv
module pcx_cond_track #(
  parameter int MASK_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load_en,
  input  logic [MASK_W-1:0] load_mask,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              arm_en,
  output logic              head_bit,
  output logic              active
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MASK_W);
  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

  logic [MASK_W-1:0] mask_q, mask_d;
  logic [LEN_W-1:0]  len_q, len_d;

  assign active   = (len_q != '0);
  assign head_bit = mask_q[0];

  always_comb begin
    mask_d = mask_q;
    len_d  = len_q;
    if (load_en) begin
      mask_d = load_mask;
      len_d  = (load_len > MAX_LEN) ? MAX_LEN : load_len;
    end else if (arm_en) begin
      mask_d = MASK_W'(1);
      len_d  = ONE_LEN;
    end else if (active) begin
      mask_d = {1'b0, mask_q[MASK_W-1:1]};
      len_d  = len_q - ONE_LEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      len_q  <= '0;
    end else if (adv) begin
      mask_q <= mask_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/pcx_count_track.sv
module pcx_count_track
  import pcx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load_en,
  input  logic [1:0]       load_mode,
  input  logic [LEN_W-1:0] load_len,
  output win_mode_e        mode,
  output logic             active
);

  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

  win_mode_e        mode_q, mode_d;
  logic [LEN_W-1:0] len_q, len_d;

  assign active = (len_q != '0);
  assign mode   = mode_q;

  always_comb begin
    mode_d = mode_q;
    len_d  = len_q;
    if (load_en) begin
      mode_d = win_mode_e'(load_mode);
      len_d  = load_len;
    end else if (active) begin
      len_d  = len_q - ONE_LEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NONE;
      len_q  <= '0;
    end else if (adv) begin
      mode_q <= mode_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/pcx_unit.sv
module pcx_unit
  import pcx_pkg::*;
#(
  parameter int W      = 16,
  parameter int PINS   = 4,
  parameter int MASK_W = 8,
  parameter int LEN_W  = 4,
  localparam int SEL_W = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_op,
  input  logic              cmp_xform,
  input  logic [W-1:0]      opnd_b,
  input  logic [W-1:0]      opnd_c,
  input  logic [PINS-1:0]   pin_in,
  input  logic [SEL_W-1:0]  pin_sel,
  input  logic              cex_valid,
  input  logic [MASK_W-1:0] cex_mask,
  input  logic [LEN_W-1:0]  cex_len,
  input  logic              cnt_valid,
  input  logic [1:0]        cnt_mode,
  input  logic [LEN_W-1:0]  cnt_len,
  input  logic              putp_valid,
  input  logic              putp_bit,
  output logic              pred_o,
  output logic              skip_o,
  output logic              carry_en_o
);

  logic      p_q, p_d;
  logic      cmp_res;
  logic      exec_en;
  logic      cond_head, cond_active;
  win_mode_e win_mode;
  logic      win_active;

  pcx_compare #(.W(W), .PINS(PINS)) u_cmp (
    .op     (cmp_op),
    .b      (opnd_b),
    .c      (opnd_c),
    .pins   (pin_in),
    .sel    (pin_sel),
    .result (cmp_res)
  );

  pcx_cond_track #(.MASK_W(MASK_W), .LEN_W(LEN_W)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (retire),
    .load_en   (exec_en & cex_valid),
    .load_mask (cex_mask),
    .load_len  (cex_len),
    .arm_en    (exec_en & cmp_valid & cmp_xform),
    .head_bit  (cond_head),
    .active    (cond_active)
  );

  pcx_count_track #(.LEN_W(LEN_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (retire),
    .load_en   (exec_en & cnt_valid),
    .load_mode (cnt_mode),
    .load_len  (cnt_len),
    .mode      (win_mode),
    .active    (win_active)
  );

  assign skip_o     = cond_active & (cond_head != p_q);
  assign exec_en    = retire & ~skip_o;
  assign carry_en_o = win_active & (win_mode == MODE_CARRY);
  assign pred_o     = p_q;

  always_comb begin
    p_d = p_q;
    if (cmp_valid) begin
      if (win_active && win_mode == MODE_ANDP)     p_d = p_q & cmp_res;
      else if (win_active && win_mode == MODE_ORP) p_d = p_q | cmp_res;
      else                                          p_d = cmp_res;
    end else if (putp_valid) begin
      p_d = putp_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       p_q <= 1'b0;
    else if (exec_en) p_q <= p_d;
  end

endmodule

// File: rtl/pcx_unit_chk.sv
module pcx_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic retire,
  input logic cmp_valid,
  input logic cmp_xform,
  input logic cex_valid,
  input logic cnt_valid,
  input logic [1:0] cnt_mode,
  input logic [3:0] cnt_len,
  input logic putp_valid,
  input logic putp_bit,
  input logic pred_o,
  input logic skip_o,
  input logic carry_en_o
);

  // Input rule: one command per retiring instruction (R8 relies on it)
  assert_one_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $onehot0({cmp_valid, cex_valid, cnt_valid, putp_valid}));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> ($stable(pred_o) && $stable(skip_o) && $stable(carry_en_o)));

  assert_skip_keeps_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && skip_o) |=> (pred_o == $past(pred_o)));

  assert_xform_gates_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !skip_o && cmp_valid && cmp_xform) |=> (skip_o == !pred_o));

  assert_putp_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !skip_o && putp_valid) |=> (pred_o == $past(putp_bit)));

  assert_carry_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !skip_o && cnt_valid && cnt_mode == 2'd0 && cnt_len != 4'd0)
      |=> carry_en_o);

endmodule

bind pcx_unit pcx_unit_chk chk_i (.*);

// File: tb/pcx_unit_tb.sv
`timescale 1ns/1ps
module pcx_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire, cmp_valid, cmp_xform, cex_valid, cnt_valid, putp_valid, putp_bit;
  logic [2:0]  cmp_op;
  logic [15:0] opnd_b, opnd_c;
  logic [3:0]  pin_in;
  logic [1:0]  pin_sel, cnt_mode;
  logic [7:0]  cex_mask;
  logic [3:0]  cex_len, cnt_len;
  logic        pred_o, skip_o, carry_en_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int m_p, m_mask, m_clen, m_mode, m_cnt;

  always #4 clk = ~clk;

  pcx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .retire(retire), .cmp_valid(cmp_valid),
    .cmp_op(cmp_op), .cmp_xform(cmp_xform), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .pin_in(pin_in), .pin_sel(pin_sel), .cex_valid(cex_valid), .cex_mask(cex_mask),
    .cex_len(cex_len), .cnt_valid(cnt_valid), .cnt_mode(cnt_mode), .cnt_len(cnt_len),
    .putp_valid(putp_valid), .putp_bit(putp_bit), .pred_o(pred_o), .skip_o(skip_o),
    .carry_en_o(carry_en_o)
  );

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  function automatic int m_skip();
    return (m_clen > 0 && (m_mask & 1) != m_p) ? 1 : 0;
  endfunction

  function automatic int eval(int op, int b, int c, int sel);
    logic signed [15:0] sb, sc;
    sb = 16'(b); sc = 16'(c);
    case (op)
      0: return (b == c);
      1: return (b != c);
      2: return (sb < sc);
      3: return (b < c);
      4: return (sb >= sc);
      5: return (b >= c);
      6: return ((b & c) != 0);
      default: return int'(pin_in[sel]);
    endcase
  endfunction

  // kind: 0 plain, 1 compare, 2 cond load, 3 modifier load, 4 direct write
  task automatic instr(string tag, bit ret, int kind, int op = 0, bit x = 0,
                       int b = 0, int c = 0, int sel = 0, int mask = 0,
                       int len = 0, int mode = 0, bit pv = 0);
    int sk, r, inwin;
    retire = ret; cmp_valid = (kind == 1); cex_valid = (kind == 2);
    cnt_valid = (kind == 3); putp_valid = (kind == 4);
    cmp_op = 3'(op); cmp_xform = x; opnd_b = 16'(b); opnd_c = 16'(c);
    pin_sel = 2'(sel); cex_mask = 8'(mask); cex_len = 4'(len);
    cnt_mode = 2'(mode); cnt_len = 4'(len); putp_bit = pv;
    if (ret) begin
      sk = m_skip();
      inwin = (m_cnt > 0);
      if (m_clen > 0) begin m_mask = m_mask >> 1; m_clen--; end
      if (m_cnt > 0) m_cnt--;
      if (!sk) begin
        case (kind)
          1: begin
            r = eval(op, b & 16'hFFFF, c & 16'hFFFF, sel);
            if (inwin && m_mode == 1)      m_p = m_p & r;
            else if (inwin && m_mode == 2) m_p = m_p | r;
            else                           m_p = r;
            if (x) begin m_mask = 1; m_clen = 1; end
          end
          2: begin m_mask = mask & 8'hFF; m_clen = (len > 8) ? 8 : len; end
          3: begin m_mode = mode; m_cnt = len; end
          4: m_p = pv;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "pred_o", int'(pred_o), m_p);
    chk(tag, "skip_o", int'(skip_o), m_skip());
    chk(tag, "carry_en_o", int'(carry_en_o), (m_cnt > 0 && m_mode == 0) ? 1 : 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; retire = 0; cmp_valid = 0; cmp_xform = 0; cex_valid = 0;
    cnt_valid = 0; putp_valid = 0; putp_bit = 0; cmp_op = 0; opnd_b = 0;
    opnd_c = 0; pin_in = 4'b0100; pin_sel = 0; cex_mask = 0; cex_len = 0;
    cnt_mode = 0; cnt_len = 0;
    m_p = 0; m_mask = 0; m_clen = 0; m_mode = 3; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "pred_o", int'(pred_o), 0);
    chk("R1", "skip_o", int'(skip_o), 0);
    chk("R1", "carry_en_o", int'(carry_en_o), 0);

    // R2 each compare code
    instr("R2", 1, 1, 0, 0, 5, 5);           chk("R2", "EQ", int'(pred_o), 1);
    instr("R2", 1, 1, 1, 0, 5, 5);           chk("R2", "NE", int'(pred_o), 0);
    instr("R2", 1, 1, 2, 0, 16'h8000, 1);    chk("R2", "LT", int'(pred_o), 1);
    instr("R2", 1, 1, 3, 0, 16'h8000, 1);    chk("R2", "LTU", int'(pred_o), 0);
    instr("R2", 1, 1, 4, 0, 16'hFFFF, 0);    chk("R2", "GE", int'(pred_o), 0);
    instr("R2", 1, 1, 5, 0, 16'hFFFF, 0);    chk("R2", "GEU", int'(pred_o), 1);
    instr("R2", 1, 1, 6, 0, 16'h00F0, 16'h0100); chk("R2", "ANY none", int'(pred_o), 0);
    instr("R2", 1, 1, 6, 0, 16'h00F0, 16'h0010); chk("R2", "ANY hit", int'(pred_o), 1);

    // R3 pin compare, pins = 0100
    instr("R3", 1, 1, 7, 0, 0, 0, 1);        chk("R3", "pin1", int'(pred_o), 0);
    instr("R3", 1, 1, 7, 0, 0, 0, 2);        chk("R3", "pin2", int'(pred_o), 1);

    // R4 X-form true then false
    instr("R4", 1, 1, 0, 1, 3, 3);           chk("R4", "skip after true", int'(skip_o), 0);
    instr("R4", 1, 0);
    instr("R4", 1, 1, 0, 1, 3, 4);           chk("R4", "skip after false", int'(skip_o), 1);
    // R8 skipped direct write has no effect
    instr("R8", 1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", "pred after skipped write", int'(pred_o), 0);

    // R9 direct write, R5 pattern 0101 over 4
    instr("R9", 1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 1); chk("R9", "putp", int'(pred_o), 1);
    instr("R5", 1, 2, 0, 0, 0, 0, 0, 8'b0000_0101, 4);
    chk("R5", "slot0", int'(skip_o), 0);
    instr("R5", 1, 0); chk("R5", "slot1", int'(skip_o), 1);
    instr("R5", 1, 0); chk("R5", "slot2", int'(skip_o), 0);
    instr("R5", 1, 0); chk("R5", "slot3", int'(skip_o), 1);
    instr("R5", 1, 0); chk("R5", "after", int'(skip_o), 0);
    // R5 clamp: len 12 with all-zero mask and P=1 skips 8 then stops
    instr("R5", 1, 2, 0, 0, 0, 0, 0, 0, 12);
    for (int i = 0; i < 8; i++) instr("R5", 1, 0);
    chk("R5", "clamped end", int'(skip_o), 0);

    // R6 carry window with idle cycles (R10)
    instr("R6", 1, 3, 0, 0, 0, 0, 0, 0, 3, 0);
    chk("R6", "carry on", int'(carry_en_o), 1);
    instr("R10", 0, 1, 1, 0, 1, 2);
    chk("R10", "idle keeps carry", int'(carry_en_o), 1);
    for (int i = 0; i < 3; i++) instr("R6", 1, 0);
    chk("R6", "carry off", int'(carry_en_o), 0);

    // R7 AND then OR windows
    instr("R7", 1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    instr("R7", 1, 3, 0, 0, 0, 0, 0, 0, 2, 1);
    instr("R7", 1, 1, 0, 0, 1, 1);           chk("R7", "and true", int'(pred_o), 1);
    instr("R7", 1, 1, 0, 0, 1, 2);           chk("R7", "and false", int'(pred_o), 0);
    instr("R7", 1, 3, 0, 0, 0, 0, 0, 0, 1, 2);
    instr("R7", 1, 1, 0, 0, 1, 1);           chk("R7", "or", int'(pred_o), 1);
    instr("R7", 1, 1, 0, 0, 1, 2);           chk("R7", "replace", int'(pred_o), 0);

    // R11 both windows at once
    instr("R11", 1, 3, 0, 0, 0, 0, 0, 0, 4, 0);
    instr("R11", 1, 2, 0, 0, 0, 0, 0, 8'b11, 2);
    instr("R11", 1, 0); instr("R11", 1, 0);
    chk("R11", "cond done", int'(skip_o), 0);
    chk("R11", "count left", int'(carry_en_o), 1);
    instr("R11", 1, 0); instr("R11", 1, 0);
    chk("R11", "count done", int'(carry_en_o), 0);

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int k, ret;
      pin_in = 4'($urandom);
      ret = ($urandom % 5) != 0;
      k = $urandom % 5;
      instr("R8", 1'(ret), k, $urandom % 8, 1'($urandom), $urandom % 6,
            $urandom % 6, $urandom % 4, $urandom, $urandom % 16, $urandom % 4,
            1'($urandom));
      if (!ret) begin
        // idle cycle with overlapping valids (R10)
        retire = 0; cmp_valid = 1; cex_valid = 1; cnt_valid = 1; putp_valid = 1;
        @(posedge clk); @(negedge clk);
        chk("R10", "pred idle", int'(pred_o), m_p);
        chk("R10", "skip idle", int'(skip_o), m_skip());
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule